// File: doc/BRIEF.md
# Reference-Windowed Clock Frequency Meter

This block measures the frequency of one clock picked from two groups of candidate clocks. It opens a gate for a programmable number of cycles of a reference clock, nominally 26 MHz, and counts rising edges of the picked clock while the gate is open. Software sets the two source indices, the path select, an optional divide-by-two and the window length. It then sets a trigger bit and polls it until hardware clears it. The 16-bit edge count is then valid. With a window of 1024 reference cycles, software converts the count to kHz as count × 26000 / 1024, and doubles the result when the divide-by-two was on.

The block spans three clock domains. The register clock domain holds the programming model. The reference domain runs the window state machine. The counter runs in the measured-clock domain, with its gate synchronised into that domain. The window state machine holds the counter in clear while no measurement runs. The count is sampled into the reference domain after a settle delay, and is handed to the register domain on a four-phase done/busy handshake.

Top module: `freq_meter`

## Requirements
- R1: After reset every register reads 0: control (word 0), count (word 1), source select (word 2) and pre-divider (word 3).
- R2: Writable fields read back, and all other bits read 0. Control: enable at bit 12. Count: window load at bits 25:16. Source select: group-A index at bits 21:16, group-B index at bits 13:8, path at bits 1:0. Pre-divider: bits 31:24.
- R3: A measurement gates the counter for exactly load+1 reference cycles. The result at count bits 15:0 equals the number of counted edges in that window, within two edges.
- R4: Path 0 counts group-A clock number index A. Path 1 counts group-B clock number index B. Path values 2 and 3, and an index at or beyond the group size, select no clock.
- R5: A pre-divider value of exactly 1 halves the selected clock before counting. Any other value counts it undivided.
- R6: Writing control with bit 12 and bit 4 set starts a measurement. Bit 4 reads 1 from that write until the result is valid, then reads 0. A write with bit 12 clear never starts one.
- R7: While a measurement runs, control writes that keep the enable set leave bit 4 at 1. They do not alter or restart the measurement, so exactly one result arrives.
- R8: Writing control with bit 12 clear aborts a running measurement. Bit 4 reads 0 within 60 register-clock cycles, and the previous result is kept.
- R9: A selected source that does not toggle still ends on reference cycles, with a result of 0.
- R10: The result saturates at 0xFFFF instead of wrapping.
- R11: Count bits 15:0 are read-only. Writes to them do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset, register domain |
| ref_clk | input | 1 | Reference clock that times the window |
| src_a | input | NUM_A | Group-A candidate clocks |
| src_b | input | NUM_B | Group-B candidate clocks |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
A register write shows in the read data one register cycle later. The bench therefore writes on a falling edge and reads back at the middle of the following cycle. A measurement result is due after the run request crosses two reference flops, then one arm cycle, load+1 window cycles, the settle delay, and two register flops. The bench polls the trigger bit once per register cycle against a bound built from that sum, and reads the count only after the bit reads 0. An abort must reach the trigger bit within two reference flops plus two register flops, so that check waits a fixed 60 register cycles. Expected counts come from the bench's own clock periods as (load+1)·Tref/Tsrc, with a two-edge allowance for gate synchronisation.

// File: rtl/fm_pkg.sv
package fm_pkg;

    localparam int REG_W   = 32;
    localparam int IDX_W   = 6;
    localparam int RES_W   = 16;
    localparam int LOAD_W  = 10;
    localparam int DIV_W   = 8;
    localparam int PATH_W  = 2;

    // field positions that software decodes
    localparam int CTRL_EN_BIT   = 12;
    localparam int CTRL_TRIG_BIT = 4;
    localparam int LOAD_LSB      = 16;
    localparam int SEL_A_LSB     = 16;
    localparam int SEL_B_LSB     = 8;
    localparam int PATH_LSB      = 0;
    localparam int DIV_LSB       = 24;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_COUNT  = 2'd1,
        ADDR_SRC    = 2'd2,
        ADDR_PREDIV = 2'd3
    } fm_addr_e;

    typedef enum logic [2:0] {
        WS_IDLE   = 3'd0,
        WS_ARM    = 3'd1,
        WS_COUNT  = 3'd2,
        WS_SETTLE = 3'd3,
        WS_DONE   = 3'd4
    } fm_win_e;

    typedef struct packed {
        logic [IDX_W-1:0]  sel_a;
        logic [IDX_W-1:0]  sel_b;
        logic [PATH_W-1:0] path;
        logic [DIV_W-1:0]  prediv;
        logic [LOAD_W-1:0] load;
    } fm_cfg_t;

    function automatic logic halve_en(input logic [DIV_W-1:0] d);
        return d == DIV_W'(1);
    endfunction

endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/fm_regs.sv
module fm_regs
    import fm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output fm_cfg_t          cfg,
    output logic             run,
    input  logic             done_s,
    input  logic             busy_s,
    input  logic [RES_W-1:0] res_in
);
    fm_cfg_t          cfg_q;
    logic             en_q;
    logic             trig_q;
    logic [RES_W-1:0] result_q;
    logic             busy;
    logic             ctrl_wr;
    fm_addr_e         addr;

    assign addr    = fm_addr_e'(bus_addr);
    assign busy    = trig_q | busy_s;
    assign ctrl_wr = bus_wr && (addr == ADDR_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            en_q     <= 1'b0;
            trig_q   <= 1'b0;
            result_q <= '0;
        end else begin
            if (bus_wr) begin
                case (addr)
                    ADDR_CTRL: begin
                        en_q <= bus_wdata[CTRL_EN_BIT];
                        if (!bus_wdata[CTRL_EN_BIT])
                            trig_q <= 1'b0;
                        else if (!busy)
                            trig_q <= bus_wdata[CTRL_TRIG_BIT];
                    end
                    ADDR_COUNT:  cfg_q.load   <= bus_wdata[LOAD_LSB +: LOAD_W];
                    ADDR_SRC: begin
                        cfg_q.sel_a <= bus_wdata[SEL_A_LSB +: IDX_W];
                        cfg_q.sel_b <= bus_wdata[SEL_B_LSB +: IDX_W];
                        cfg_q.path  <= bus_wdata[PATH_LSB +: PATH_W];
                    end
                    ADDR_PREDIV: cfg_q.prediv <= bus_wdata[DIV_LSB +: DIV_W];
                    default: ;
                endcase
            end
            if (trig_q && done_s) begin
                result_q <= res_in;
                trig_q   <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (addr)
            ADDR_CTRL: begin
                bus_rdata[CTRL_EN_BIT]   = en_q;
                bus_rdata[CTRL_TRIG_BIT] = busy;
            end
            ADDR_COUNT: begin
                bus_rdata[LOAD_LSB +: LOAD_W] = cfg_q.load;
                bus_rdata[RES_W-1:0]          = result_q;
            end
            ADDR_SRC: begin
                bus_rdata[SEL_A_LSB +: IDX_W]  = cfg_q.sel_a;
                bus_rdata[SEL_B_LSB +: IDX_W]  = cfg_q.sel_b;
                bus_rdata[PATH_LSB +: PATH_W]  = cfg_q.path;
            end
            ADDR_PREDIV: bus_rdata[DIV_LSB +: DIV_W] = cfg_q.prediv;
            default: ;
        endcase
    end

    logic unused_wdata;
    assign unused_wdata = ^{bus_wdata[15:14], bus_wdata[7:5], bus_wdata[3:2]};

    assign cfg = cfg_q;
    assign run = trig_q;

    // R6
    trig_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        trig_q |-> en_q);

    // R7
    busy_trig_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && bus_wdata[CTRL_EN_BIT] && busy && !(trig_q && done_s))
        |=> (trig_q == $past(trig_q)));

    // R6
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_q && done_s) |=> !trig_q);
endmodule

// File: rtl/fm_window.sv
module fm_window
    import fm_pkg::*;
#(
    parameter int SETTLE_CYC = 16
) (
    input  logic              ref_clk,
    input  logic              ref_rst,
    input  logic              run_s,
    input  logic [LOAD_W-1:0] load,
    input  logic [RES_W-1:0]  meas_cnt,
    output logic              gate,
    output logic              meas_clr,
    output logic              done,
    output logic              busy,
    output logic [RES_W-1:0]  result
);
    localparam int SET_W = $clog2(SETTLE_CYC + 1);

    fm_win_e           state, nxt;
    logic [LOAD_W-1:0] load_q;
    logic [LOAD_W-1:0] win_q;
    logic [SET_W-1:0]  set_q;

    always_comb begin
        nxt = state;
        case (state)
            WS_IDLE:   if (run_s) nxt = WS_ARM;
            WS_ARM:    nxt = WS_COUNT;
            WS_COUNT:  if (win_q == '0) nxt = WS_SETTLE;
            WS_SETTLE: if (set_q == '0) nxt = WS_DONE;
            WS_DONE:   nxt = WS_DONE;
            default:   nxt = WS_IDLE;
        endcase
        if (!run_s) nxt = WS_IDLE;
    end

    always_ff @(posedge ref_clk) begin
        if (ref_rst) begin
            state    <= WS_IDLE;
            gate     <= 1'b0;
            meas_clr <= 1'b1;
            done     <= 1'b0;
            busy     <= 1'b0;
            load_q   <= '0;
            win_q    <= '0;
            set_q    <= '0;
            result   <= '0;
        end else begin
            state    <= nxt;
            gate     <= (nxt == WS_COUNT);
            meas_clr <= (nxt == WS_IDLE);
            done     <= (nxt == WS_DONE);
            busy     <= (nxt != WS_IDLE);
            if (state == WS_IDLE && run_s) load_q <= load;
            if (state == WS_ARM)
                win_q <= load_q;
            else if (state == WS_COUNT && win_q != '0)
                win_q <= win_q - 1'b1;
            if (state == WS_COUNT && win_q == '0)
                set_q <= SET_W'(SETTLE_CYC - 1);
            else if (state == WS_SETTLE && set_q != '0)
                set_q <= set_q - 1'b1;
            if (state == WS_SETTLE && set_q == '0 && run_s)
                result <= meas_cnt;
        end
    end

    // window length observer
    logic [LOAD_W:0] gate_len;
    always_ff @(posedge ref_clk) begin
        if (ref_rst)   gate_len <= '0;
        else if (gate) gate_len <= gate_len + 1'b1;
        else           gate_len <= '0;
    end

    // R3
    window_len_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
        ($fell(gate) && $past(run_s)) |-> (gate_len == {1'b0, load_q} + 1'b1));

    // R3
    gate_done_excl_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
        !(gate && done));

    // R8
    abort_idle_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (!run_s && busy) |=> !busy && !gate);
endmodule

// File: rtl/fm_meter_path.sv
module fm_meter_path
    import fm_pkg::*;
#(
    parameter int NUM_A = 4,
    parameter int NUM_B = 4
) (
    input  logic [NUM_A-1:0]  src_a,
    input  logic [NUM_B-1:0]  src_b,
    input  logic [IDX_W-1:0]  sel_a,
    input  logic [IDX_W-1:0]  sel_b,
    input  logic [PATH_W-1:0] path,
    input  logic              halve,
    input  logic              meas_clr,
    input  logic              gate,
    output logic [RES_W-1:0]  cnt
);
    localparam int SLOTS = 1 << IDX_W;

    logic [SLOTS-1:0] pad_a, pad_b;

    for (genvar i = 0; i < SLOTS; i++) begin : g_pad
        if (i < NUM_A) begin : g_a_live
            assign pad_a[i] = src_a[i];
        end else begin : g_a_none
            assign pad_a[i] = 1'b0;
        end
        if (i < NUM_B) begin : g_b_live
            assign pad_b[i] = src_b[i];
        end else begin : g_b_none
            assign pad_b[i] = 1'b0;
        end
    end

    logic src_clk;
    always_comb begin
        case (path)
            2'd0:    src_clk = pad_a[sel_a];
            2'd1:    src_clk = pad_b[sel_b];
            default: src_clk = 1'b0;
        endcase
    end

    logic half_q;
    always_ff @(posedge src_clk or posedge meas_clr) begin
        if (meas_clr) half_q <= 1'b0;
        else          half_q <= ~half_q;
    end

    logic cnt_clk;
    assign cnt_clk = halve ? half_q : src_clk;

    logic gate_m1, gate_m2;
    always_ff @(posedge cnt_clk or posedge meas_clr) begin
        if (meas_clr) begin
            gate_m1 <= 1'b0;
            gate_m2 <= 1'b0;
            cnt     <= '0;
        end else begin
            gate_m1 <= gate;
            gate_m2 <= gate_m1;
            if (gate_m2 && cnt != '1) cnt <= cnt + 1'b1;
        end
    end

    // R10
    sat_hold_chk: assert property (@(posedge cnt_clk) disable iff (meas_clr)
        (cnt == '1) |=> (cnt == '1));

    // R3
    closed_gate_hold_chk: assert property (@(posedge cnt_clk) disable iff (meas_clr)
        !gate_m2 |=> $stable(cnt));
endmodule

// File: rtl/freq_meter.sv
module freq_meter
    import fm_pkg::*;
#(
    parameter int NUM_A       = 4,
    parameter int NUM_B       = 4,
    parameter int SETTLE_CYC  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_clk,
    input  logic [NUM_A-1:0] src_a,
    input  logic [NUM_B-1:0] src_b,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata
);
    fm_cfg_t          cfg;
    logic             run, run_s;
    logic             ref_rst;
    logic             gate, meas_clr, done_r, busy_r;
    logic             done_s, busy_s;
    logic [RES_W-1:0] meas_cnt, ref_result;

    fm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_ref (
        .clk(ref_clk), .rst(1'b0), .d(rst), .q(ref_rst)
    );

    fm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_run_ref (
        .clk(ref_clk), .rst(ref_rst), .d(run), .q(run_s)
    );

    fm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_stat_reg (
        .clk(clk), .rst(rst), .d({done_r, busy_r}), .q({done_s, busy_s})
    );

    fm_regs u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cfg(cfg), .run(run),
        .done_s(done_s), .busy_s(busy_s), .res_in(ref_result)
    );

    fm_window #(.SETTLE_CYC(SETTLE_CYC)) u_window (
        .ref_clk(ref_clk), .ref_rst(ref_rst),
        .run_s(run_s), .load(cfg.load), .meas_cnt(meas_cnt),
        .gate(gate), .meas_clr(meas_clr), .done(done_r), .busy(busy_r),
        .result(ref_result)
    );

    fm_meter_path #(.NUM_A(NUM_A), .NUM_B(NUM_B)) u_path (
        .src_a(src_a), .src_b(src_b),
        .sel_a(cfg.sel_a), .sel_b(cfg.sel_b), .path(cfg.path),
        .halve(halve_en(cfg.prediv)),
        .meas_clr(meas_clr), .gate(gate), .cnt(meas_cnt)
    );
endmodule

// File: tb/tb_freq_meter.sv
`timescale 1ns/1ps
module tb_freq_meter;
    logic        clk = 0, rst = 1, ref_clk = 0;
    logic [3:0]  src_a = '0, src_b = '0;
    logic        bus_wr = 0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fast_on = 0;

    int checks = 0, errors = 0, cycles = 0;
    bit finished = 0;

    // periods in ps; 0 marks a quiet input
    int per_a [4] = '{10000, 16000, 24000, 0};
    int per_b [4] = '{8000, 20000, 500, 50000};
    localparam int REF_PS = 40000;

    freq_meter dut (
        .clk(clk), .rst(rst), .ref_clk(ref_clk),
        .src_a(src_a), .src_b(src_b),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    always #2   clk = ~clk;
    always #20  ref_clk = ~ref_clk;
    always #5   src_a[0] = ~src_a[0];
    always #8   src_a[1] = ~src_a[1];
    always #12  src_a[2] = ~src_a[2];
    always #4   src_b[0] = ~src_b[0];
    always #10  src_b[1] = ~src_b[1];
    always #25  src_b[3] = ~src_b[3];
    always begin
        wait (fast_on);
        #0.25 src_b[2] = ~src_b[2];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a[1:0]; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a[1:0];
        #1 v = bus_rdata;
    endtask

    function automatic int expect_cnt(input int path, input int idx, input int dv, input int load);
        int t;
        if (path == 0 && idx < 4)      t = per_a[idx];
        else if (path == 1 && idx < 4) t = per_b[idx];
        else                           t = 0;
        if (path == 1 && idx == 2 && !fast_on) t = 0;
        if (t == 0) return 0;
        if (dv == 1) t = t * 2;
        return (load + 1) * REF_PS / t;
    endfunction

    task automatic start_meas(input int path, input int idx, input int dv, input int load);
        logic [31:0] s;
        s = (path == 0) ? (idx << 16) : (idx << 8);
        bus_write(2, s | path);
        bus_write(3, dv << 24);
        bus_write(1, load << 16);
        bus_write(0, 32'h0000_1010);
    endtask

    task automatic wait_done(input int load, input string req, output logic [31:0] cnt_v);
        logic [31:0] v;
        int lim = (load + 1 + 40) * 10 + 200;
        int n = 0;
        v = 32'h10;
        while (v[4] && n < lim) begin
            bus_read(0, v);
            n++;
        end
        check(!v[4], req, "trigger self-clear", v[4], 0);
        bus_read(1, cnt_v);
    endtask

    task automatic measure(input int path, input int idx, input int dv, input int load,
                           input int tol, input string req);
        logic [31:0] v;
        int e, d;
        e = expect_cnt(path, idx, dv, load);
        start_meas(path, idx, dv, load);
        wait_done(load, req, v);
        d = int'(v[15:0]) - e;
        if (d < 0) d = -d;
        check(d <= tol, req, $sformatf("count p%0d i%0d d%0d l%0d", path, idx, dv, load),
              v[15:0], e);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 190000 && !finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, prev;
        repeat (20) @(negedge clk);
        rst = 0;
        repeat (10) @(negedge clk);

        // R1 reset values
        for (int a = 0; a < 4; a++) begin
            bus_read(a, v);
            check(v == 0, "R1", $sformatf("reset word %0d", a), v, 0);
        end

        // R2 field readback
        bus_write(2, 32'hFFFF_FFFF); bus_read(2, v);
        check(v == 32'h003F_3F03, "R2", "source select", v, 32'h003F_3F03);
        bus_write(3, 32'hFFFF_FFFF); bus_read(3, v);
        check(v == 32'hFF00_0000, "R2", "pre-divider", v, 32'hFF00_0000);
        bus_write(1, 32'hFFFF_FFFF); bus_read(1, v);
        check(v == 32'h03FF_0000, "R2 R11", "count word", v, 32'h03FF_0000);
        bus_write(0, 32'hFFFF_FFEF); bus_read(0, v);
        check(v == 32'h0000_1000, "R2", "control", v, 32'h0000_1000);

        // R6 trigger without enable never starts
        bus_write(0, 32'h0000_0010);
        repeat (60) @(negedge clk);
        bus_read(0, v);
        check(v == 0, "R6", "trigger with enable clear", v, 0);

        // R3 R4 R5 R9 sweep over both groups, each index and divider
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 4; i++)
                for (int dv = 0; dv < 2; dv++)
                    measure(p, i, dv, 63, 2, (expect_cnt(p, i, dv, 63) == 0) ? "R9" :
                                             (dv == 1) ? "R5" : "R4");

        // R3 other window lengths
        measure(0, 1, 0, 15, 2, "R3");
        measure(0, 1, 0, 127, 2, "R3");
        // R5 non-unity divider value passes through
        measure(1, 1, 2, 63, 2, "R5");
        // R4 no-clock selections
        measure(2, 0, 0, 31, 0, "R4");
        measure(0, 9, 0, 31, 0, "R4");
        measure(1, 40, 0, 31, 0, "R4");

        // R11 writes to result bits ignored
        bus_read(1, prev);
        bus_write(1, 32'h003F_ABCD);
        bus_read(1, v);
        check(v[15:0] == prev[15:0], "R11", "result after write", v[15:0], prev[15:0]);

        // R7 writes while running are ignored
        start_meas(0, 0, 0, 63);
        repeat (100) @(negedge clk);
        bus_write(0, 32'h0000_1010);
        bus_write(0, 32'h0000_1000);
        bus_read(0, v);
        check(v[4] == 1, "R7", "trigger held during run", v[4], 1);
        wait_done(63, "R7", v);
        check((int'(v[15:0]) >= 254) && (int'(v[15:0]) <= 258), "R7", "single result",
              v[15:0], 256);
        repeat (80) @(negedge clk);
        bus_read(0, v);
        check(v[4] == 0, "R7", "no second run", v[4], 0);

        // R8 abort keeps old result
        bus_read(1, prev);
        start_meas(1, 0, 0, 255);
        repeat (200) @(negedge clk);
        bus_write(0, 32'h0000_0000);
        repeat (60) @(negedge clk);
        bus_read(0, v);
        check(v == 0, "R8", "abort clears trigger", v, 0);
        bus_read(1, v);
        check(v[15:0] == prev[15:0], "R8", "result kept", v[15:0], prev[15:0]);
        measure(1, 0, 0, 31, 2, "R8");

        // R10 saturation
        fast_on = 1;
        start_meas(1, 2, 0, 1023);
        wait_done(1023, "R10", v);
        check(v[15:0] == 16'hFFFF, "R10", "saturated count", v[15:0], 16'hFFFF);
        fast_on = 0;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule